// File: doc/BRIEF.md
# Tagged Configuration Header Parser

This block sits at the front of a configuration-image loader. It takes the image one byte at a time on a valid/ready stream and removes the leading header. It does not store the header's text fields. It walks a fixed run of single-letter tags, checks that each tag is the expected letter, reads each tag's big-endian length, and counts off the field bytes without keeping them. The final tag carries a 32-bit length for the raw payload instead of a text field. The block captures that length, pulses a header-done strobe, and then forwards exactly that many payload bytes downstream. The first payload byte is marked.

The sender marks the last byte of the image with an end flag. If that flag arrives before the image is complete, the block raises a truncation flag. A tag with the wrong letter raises a format flag. After either error the block accepts and drops all further input until a synchronous restart pulse returns it to its initial state. Downstream backpressure reaches upstream during the payload phase only. In every other phase input is always accepted.

Top module: `cfg_hdr_strip`

## Requirements
- R1: After reset, outValid, outFirst, hdrDone, fmtErr and truncErr are 0, payLen is 0, and inReady is 1.
- R2: The first SKIP_BYTES bytes (default 13) are accepted and dropped without being checked, even when they equal tag letters.
- R3: Tag letters 0x61, 0x62, 0x63 and 0x64 must appear in that order. Each is followed by a 2-byte length, most significant byte first, and then that many field bytes, which are dropped. No header byte ever appears on the output.
- R4: A field length of zero makes the very next byte a tag position.
- R5: Tag 0x65 follows the fourth field and is followed by a 4-byte payload length, most significant byte first. hdrDone is high for exactly the one cycle after the last length byte is accepted. From that cycle on, payLen holds the length and changes only at a later hdrDone or at restart.
- R6: A byte at a tag position that is not the expected letter sets fmtErr in the following cycle. fmtErr stays set until restart. All later bytes are accepted (inReady 1) and produce no output.
- R7: Payload bytes are output in arrival order. Each appears on outData with outValid in the cycle after it is accepted. outFirst is 1 only with the first payload byte.
- R8: Exactly payLen bytes are forwarded. Bytes after them are accepted and dropped.
- R9: A payload length of zero pulses hdrDone and forwards no byte.
- R10: If an accepted byte carries inEnd before the image is complete, truncErr is set in the next cycle. It stays set until restart, and later input is dropped. inEnd on the byte that completes the image, or on any later byte, sets nothing.
- R11: In the payload phase, inReady is 0 while an output byte is held with outReady low. A held output keeps outData and outFirst unchanged.
- R12: A restart pulse holds inReady at 0 for that cycle. From the next cycle the block is in its reset state: flags, payLen and outValid are cleared, and header parsing begins again at the skip phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart to the initial parse state |
| inData | input | 8 | Input image byte |
| inValid | input | 1 | Input byte valid |
| inEnd | input | 1 | Marks the last byte of the image |
| inReady | output | 1 | Block accepts the input byte this cycle |
| outData | output | 8 | Payload byte |
| outValid | output | 1 | Payload byte valid |
| outReady | input | 1 | Downstream accepts the payload byte |
| outFirst | output | 1 | Marks the first payload byte |
| hdrDone | output | 1 | One-cycle strobe when the payload length is captured |
| payLen | output | 32 | Captured payload length in bytes |
| fmtErr | output | 1 | Sticky flag: wrong tag letter seen |
| truncErr | output | 1 | Sticky flag: image ended early |

## Verification
inReady is combinational: it is due in the same cycle as the inputs that drive it, including outReady and restart. The bench reads it a short delay after driving the inputs at the falling edge. Every registered result is due one clock edge after the accepted byte that causes it:
- a forwarded payload byte and outFirst;
- hdrDone and payLen, after the last length byte;
- fmtErr, after the wrong tag;
- truncErr, after the early end flag.

The bench's model moves its own state on the same rising edge. It compares all outputs at the next falling edge, where the design's registers have settled. A separate count of bytes taken off the output is checked against the payload the stimulus generator built.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  typedef enum logic [3:0] {
    PH_SKIP,
    PH_TAG,
    PH_FLEN,
    PH_FIELD,
    PH_PLEN,
    PH_PAY,
    PH_DONE,
    PH_ERR
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic decCnt;
    logic ldFlen;
    logic shiftFld;
    logic ldField;
    logic ldPlen;
    logic shiftLen;
    logic ldPay;
    logic push;
    logic setFmt;
    logic setTrunc;
  } ctlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic cntOne;
    logic fieldZero;
    logic lenZero;
    logic outBusy;
  } dpStatus_t;

endpackage

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
#(
  parameter int         N_TEXT   = 4,
  parameter logic [7:0] TAG_BASE = 8'h61
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        restart,
  input  logic        inValid,
  input  logic [7:0]  inByte,
  input  logic        inEnd,
  input  dpStatus_t   sts,
  output ctlStrobe_t  stb,
  output logic        inReady
);

  localparam int TAG_W = $clog2(N_TEXT + 1);

  phase_e           phase, nxtPhase;
  logic [TAG_W-1:0] tagIdx, nxtTag;
  logic [7:0]       expTag;
  logic             acc;

  assign expTag  = TAG_BASE + 8'(tagIdx);
  assign inReady = !restart && !((phase == PH_PAY) && sts.outBusy);
  assign acc     = inValid && inReady;

  always_comb begin
    stb      = '0;
    nxtPhase = phase;
    nxtTag   = tagIdx;
    if (restart) begin
      stb.clear = 1'b1;
      nxtPhase  = PH_SKIP;
      nxtTag    = '0;
    end else if (acc) begin
      unique case (phase)
        PH_SKIP: begin
          stb.decCnt = 1'b1;
          if (sts.cntOne) begin
            nxtPhase = PH_TAG;
            nxtTag   = '0;
          end
        end
        PH_TAG: begin
          if (inByte != expTag) begin
            stb.setFmt = 1'b1;
            nxtPhase   = PH_ERR;
          end else if (tagIdx == TAG_W'(N_TEXT)) begin
            stb.ldPlen = 1'b1;
            nxtPhase   = PH_PLEN;
          end else begin
            stb.ldFlen = 1'b1;
            nxtPhase   = PH_FLEN;
          end
        end
        PH_FLEN: begin
          if (sts.cntOne) begin
            if (sts.fieldZero) begin
              nxtPhase = PH_TAG;
              nxtTag   = tagIdx + TAG_W'(1);
            end else begin
              stb.ldField = 1'b1;
              nxtPhase    = PH_FIELD;
            end
          end else begin
            stb.shiftFld = 1'b1;
            stb.decCnt   = 1'b1;
          end
        end
        PH_FIELD: begin
          stb.decCnt = 1'b1;
          if (sts.cntOne) begin
            nxtPhase = PH_TAG;
            nxtTag   = tagIdx + TAG_W'(1);
          end
        end
        PH_PLEN: begin
          if (sts.cntOne) begin
            stb.ldPay = 1'b1;
            nxtPhase  = sts.lenZero ? PH_DONE : PH_PAY;
          end else begin
            stb.shiftLen = 1'b1;
            stb.decCnt   = 1'b1;
          end
        end
        PH_PAY: begin
          stb.push   = 1'b1;
          stb.decCnt = 1'b1;
          if (sts.cntOne) nxtPhase = PH_DONE;
        end
        default: ;
      endcase
      // an end mark anywhere short of completion is a truncation
      if (inEnd && (nxtPhase != PH_DONE) && (nxtPhase != PH_ERR)) begin
        stb.setTrunc = 1'b1;
        nxtPhase     = PH_ERR;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_SKIP;
      tagIdx <= '0;
    end else begin
      phase  <= nxtPhase;
      tagIdx <= nxtTag;
    end
  end

endmodule

// File: rtl/cfg_hdr_dp.sv
module cfg_hdr_dp
  import cfg_hdr_pkg::*;
#(
  parameter int SKIP_BYTES = 13,
  parameter int FLD_LEN_W  = 16,
  parameter int LEN_W      = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       stb,
  input  logic [7:0]       inByte,
  input  logic             outReady,
  output dpStatus_t        sts,
  output logic [7:0]       outData,
  output logic             outValid,
  output logic             outFirst,
  output logic             hdrDone,
  output logic [LEN_W-1:0] payLen,
  output logic             fmtErr,
  output logic             truncErr
);

  localparam int CNT_W     = (LEN_W > FLD_LEN_W) ? LEN_W : FLD_LEN_W;
  localparam int FLD_BYTES = FLD_LEN_W / 8;
  localparam int LEN_BYTES = LEN_W / 8;

  logic [CNT_W-1:0]     cnt;
  logic [FLD_LEN_W-9:0] fldSh;
  logic [LEN_W-9:0]     lenSh;
  logic [FLD_LEN_W-1:0] newFld;
  logic [LEN_W-1:0]     newLen;
  logic                 firstPend;

  assign newFld = {fldSh, inByte};
  assign newLen = {lenSh, inByte};

  assign sts.cntOne    = (cnt == CNT_W'(1));
  assign sts.fieldZero = (newFld == '0);
  assign sts.lenZero   = (newLen == '0);
  assign sts.outBusy   = outValid && !outReady;

  // shared down counter: skip, length bytes, field bytes, payload bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= CNT_W'(SKIP_BYTES);
    else if (stb.clear)    cnt <= CNT_W'(SKIP_BYTES);
    else if (stb.ldFlen)   cnt <= CNT_W'(FLD_BYTES);
    else if (stb.ldPlen)   cnt <= CNT_W'(LEN_BYTES);
    else if (stb.ldField)  cnt <= CNT_W'(newFld);
    else if (stb.ldPay)    cnt <= CNT_W'(newLen);
    else if (stb.decCnt)   cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fldSh <= '0;
      lenSh <= '0;
    end else begin
      if (stb.shiftFld) fldSh <= newFld[FLD_LEN_W-9:0];
      if (stb.shiftLen) lenSh <= newLen[LEN_W-9:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrDone   <= 1'b0;
      payLen    <= '0;
      fmtErr    <= 1'b0;
      truncErr  <= 1'b0;
      firstPend <= 1'b0;
    end else if (stb.clear) begin
      hdrDone   <= 1'b0;
      payLen    <= '0;
      fmtErr    <= 1'b0;
      truncErr  <= 1'b0;
      firstPend <= 1'b0;
    end else begin
      hdrDone <= stb.ldPay;
      if (stb.ldPay)    payLen   <= newLen;
      if (stb.setFmt)   fmtErr   <= 1'b1;
      if (stb.setTrunc) truncErr <= 1'b1;
      if (stb.ldPay)     firstPend <= 1'b1;
      else if (stb.push) firstPend <= 1'b0;
    end
  end

  // single output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData  <= '0;
      outValid <= 1'b0;
      outFirst <= 1'b0;
    end else if (stb.clear) begin
      outValid <= 1'b0;
      outFirst <= 1'b0;
    end else if (stb.push) begin
      outData  <= inByte;
      outValid <= 1'b1;
      outFirst <= firstPend;
    end else if (outReady) begin
      outValid <= 1'b0;
      outFirst <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_hdr_strip.sv
module cfg_hdr_strip
  import cfg_hdr_pkg::*;
#(
  parameter int         SKIP_BYTES = 13,
  parameter int         N_TEXT     = 4,
  parameter int         FLD_LEN_W  = 16,
  parameter int         LEN_W      = 32,
  parameter logic [7:0] TAG_BASE   = 8'h61
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inEnd,
  output logic             inReady,
  output logic [7:0]       outData,
  output logic             outValid,
  input  logic             outReady,
  output logic             outFirst,
  output logic             hdrDone,
  output logic [LEN_W-1:0] payLen,
  output logic             fmtErr,
  output logic             truncErr
);

  ctlStrobe_t stb;
  dpStatus_t  sts;

  cfg_hdr_ctrl #(
    .N_TEXT   (N_TEXT),
    .TAG_BASE (TAG_BASE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .restart (restart),
    .inValid (inValid),
    .inByte  (inData),
    .inEnd   (inEnd),
    .sts     (sts),
    .stb     (stb),
    .inReady (inReady)
  );

  cfg_hdr_dp #(
    .SKIP_BYTES (SKIP_BYTES),
    .FLD_LEN_W  (FLD_LEN_W),
    .LEN_W      (LEN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inByte   (inData),
    .outReady (outReady),
    .sts      (sts),
    .outData  (outData),
    .outValid (outValid),
    .outFirst (outFirst),
    .hdrDone  (hdrDone),
    .payLen   (payLen),
    .fmtErr   (fmtErr),
    .truncErr (truncErr)
  );

endmodule

// File: rtl/cfg_hdr_strip_chk.sv
module cfg_hdr_strip_chk #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             restart,
  input logic             inReady,
  input logic [7:0]       outData,
  input logic             outValid,
  input logic             outReady,
  input logic             outFirst,
  input logic             hdrDone,
  input logic [LEN_W-1:0] payLen,
  input logic             fmtErr,
  input logic             truncErr
);

  AST_HDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    hdrDone |=> !hdrDone) else $error("hdrDone longer than one cycle"); // R5

  AST_PAYLEN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !restart |=> ($stable(payLen) || hdrDone)) else $error("payLen moved"); // R5

  AST_FIRST_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outFirst |-> outValid) else $error("outFirst without outValid"); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !restart) |=> (outValid && $stable(outData) && $stable(outFirst)))
    else $error("held output changed"); // R11

  AST_FMT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (fmtErr && !restart) |=> fmtErr) else $error("fmtErr dropped"); // R6

  AST_TRUNC_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (truncErr && !restart) |=> truncErr) else $error("truncErr dropped"); // R10

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((fmtErr || truncErr) && !outValid) |=> !outValid) else $error("output after error"); // R6

  AST_RESTART_NOREADY: assert property (@(posedge clk) disable iff (!rstN)
    restart |-> !inReady) else $error("ready during restart"); // R12

  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!fmtErr && !truncErr && !outValid && !hdrDone && (payLen == '0)))
    else $error("restart left state"); // R12

endmodule

bind cfg_hdr_strip cfg_hdr_strip_chk #(.LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .restart  (restart),
  .inReady  (inReady),
  .outData  (outData),
  .outValid (outValid),
  .outReady (outReady),
  .outFirst (outFirst),
  .hdrDone  (hdrDone),
  .payLen   (payLen),
  .fmtErr   (fmtErr),
  .truncErr (truncErr)
);

// File: tb/cfg_hdr_strip_bench.sv
module cfg_hdr_strip_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        restart = 1'b0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0;
  logic        inEnd = 1'b0;
  logic        inReady;
  logic [7:0]  outData;
  logic        outValid;
  logic        outReady = 1'b1;
  logic        outFirst;
  logic        hdrDone;
  logic [31:0] payLen;
  logic        fmtErr;
  logic        truncErr;

  always #2 clk = ~clk;   // 250 MHz

  cfg_hdr_strip u_cfg_hdr_strip (
    .clk(clk), .rstN(rstN), .restart(restart), .inData(inData), .inValid(inValid),
    .inEnd(inEnd), .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outFirst(outFirst), .hdrDone(hdrDone), .payLen(payLen),
    .fmtErr(fmtErr), .truncErr(truncErr)
  );

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  int hdrSeen = 0;
  int stallSeen = 0;

  logic [7:0] stimQ[$];
  bit         endQ[$];
  logic [7:0] expPay[$];
  logic [7:0] rxQ[$];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // modes: 0 skip, 1 tag, 2 length bytes, 3 field, 4 payload length, 5 payload, 6 done, 7 error
  int     mMode, mCnt, mTag, mFld;
  longint mLen, mPay, mPayLen;
  bit     mOutValid, mOutFirst, mFirst, mHdr, mFmt, mTrunc;
  logic [7:0] mOutData;

  function automatic bit mReady();
    return !restart && !(mMode == 5 && mOutValid && !outReady);
  endfunction

  task automatic mInit();
    mMode = 0; mCnt = 13; mTag = 0; mFld = 0; mLen = 0; mPay = 0; mPayLen = 0;
    mOutValid = 0; mOutFirst = 0; mFirst = 0; mHdr = 0; mFmt = 0; mTrunc = 0;
  endtask

  task automatic mStep();
    int nm;
    bit acc;
    acc = inValid && mReady();
    if (restart) begin
      mInit();
      mOutData = mOutData;
      return;
    end
    mHdr = 0;
    if (mOutValid && outReady) begin mOutValid = 0; mOutFirst = 0; end
    if (acc) begin
      nm = mMode;
      case (mMode)
        0: begin mCnt--; if (mCnt == 0) begin nm = 1; mTag = 0; end end
        1: begin
          if (int'(inData) != 97 + mTag) begin mFmt = 1; nm = 7; end
          else if (mTag == 4) begin nm = 4; mCnt = 4; mLen = 0; end
          else begin nm = 2; mCnt = 2; mFld = 0; end
        end
        2: begin
          mFld = mFld * 256 + int'(inData); mCnt--;
          if (mCnt == 0) begin
            if (mFld == 0) begin mTag++; nm = 1; end
            else begin mCnt = mFld; nm = 3; end
          end
        end
        3: begin mCnt--; if (mCnt == 0) begin mTag++; nm = 1; end end
        4: begin
          mLen = ((mLen << 8) | longint'(inData)) & 64'hFFFF_FFFF; mCnt--;
          if (mCnt == 0) begin
            mHdr = 1; mPayLen = mLen; mPay = mLen; mFirst = 1;
            nm = (mLen == 0) ? 6 : 5;
          end
        end
        5: begin
          mOutValid = 1; mOutData = inData; mOutFirst = mFirst; mFirst = 0;
          mPay--; if (mPay == 0) nm = 6;
        end
        default: ;
      endcase
      if (inEnd && nm != 6 && nm != 7) begin mTrunc = 1; nm = 7; end
      mMode = nm;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) mInit();
    else mStep();
  end

  // ---------------- per-cycle comparison ----------------
  task automatic compareAll();
    chk("R7", "outValid", outValid, mOutValid);
    if (mOutValid) begin
      chk("R7", "outData", outData, mOutData);
      chk("R7", "outFirst", outFirst, mOutFirst);
    end
    chk("R5", "hdrDone", hdrDone, mHdr);
    chk("R5", "payLen", payLen, mPayLen);
    chk("R6", "fmtErr", fmtErr, mFmt);
    chk("R10", "truncErr", truncErr, mTrunc);
    if (hdrDone) hdrSeen++;
  endtask

  // ---------------- stimulus ----------------
  task automatic buildFile(input int skipVal, input int f0, input int f1, input int f2,
                           input int f3, input int plen, input int sendPay,
                           input int badTag, input bit endAtLast, input int trailing);
    int lens[4];
    lens[0] = f0; lens[1] = f1; lens[2] = f2; lens[3] = f3;
    stimQ.delete(); endQ.delete(); expPay.delete(); rxQ.delete();
    hdrSeen = 0; stallSeen = 0;
    for (int i = 0; i < 13; i++) begin stimQ.push_back(8'((skipVal + i) & 255)); endQ.push_back(0); end
    for (int t = 0; t < 4; t++) begin
      stimQ.push_back((t == badTag) ? 8'h78 : 8'(97 + t)); endQ.push_back(0);
      stimQ.push_back(8'(lens[t] >> 8)); endQ.push_back(0);
      stimQ.push_back(8'(lens[t] & 255)); endQ.push_back(0);
      for (int k = 0; k < lens[t]; k++) begin stimQ.push_back(8'((t * 17 + k) & 255)); endQ.push_back(0); end
    end
    stimQ.push_back((badTag == 4) ? 8'h78 : 8'h65); endQ.push_back(0);
    for (int s = 3; s >= 0; s--) begin stimQ.push_back(8'((plen >> (8 * s)) & 255)); endQ.push_back(0); end
    for (int i = 0; i < sendPay; i++) begin
      stimQ.push_back(8'((i * 7 + 3) & 255)); endQ.push_back(0);
      if (badTag < 0 && i < plen) expPay.push_back(8'((i * 7 + 3) & 255));
    end
    for (int i = 0; i < trailing; i++) begin stimQ.push_back(8'hA5); endQ.push_back(0); end
    if (endAtLast) endQ[endQ.size() - 1] = 1;
  endtask

  task automatic runStream(input int gapMod, input int stallMod, input int limit);
    int n;
    n = 0;
    while ((stimQ.size() > 0 || outValid) && n < limit) begin
      @(negedge clk);
      compareAll();
      n++;
      inValid  = (stimQ.size() > 0) && !(gapMod > 0 && (n % gapMod) == 0);
      inData   = (stimQ.size() > 0) ? stimQ[0] : 8'h00;
      inEnd    = (stimQ.size() > 0) ? endQ[0] : 1'b0;
      outReady = !(stallMod > 0 && (n % stallMod) < 2);
      #1;
      chk("R11", "inReady", inReady, mReady());
      if (!inReady) stallSeen++;
      if (outValid && outReady) rxQ.push_back(outData);
      if (inValid && inReady) begin void'(stimQ.pop_front()); void'(endQ.pop_front()); end
    end
    @(negedge clk);
    compareAll();
    inValid = 0; inEnd = 0; outReady = 1;
    @(negedge clk);
    compareAll();
  endtask

  task automatic checkPayload(input string req);
    chk(req, "payload count", rxQ.size(), expPay.size());
    for (int i = 0; i < rxQ.size() && i < expPay.size(); i++)
      chk("R7", "payload byte", rxQ[i], expPay[i]);
  endtask

  task automatic doRestart();
    @(negedge clk);
    compareAll();
    restart = 1; inValid = 0; inEnd = 0;
    #1;
    chk("R12", "inReady during restart", inReady, 0);
    @(negedge clk);
    restart = 0;
    compareAll();
    chk("R12", "fmtErr cleared", fmtErr, 0);
    chk("R12", "truncErr cleared", truncErr, 0);
    chk("R12", "payLen cleared", payLen, 0);
    chk("R12", "outValid cleared", outValid, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    mInit();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "outValid", outValid, 0);
    chk("R1", "outFirst", outFirst, 0);
    chk("R1", "hdrDone", hdrDone, 0);
    chk("R1", "fmtErr", fmtErr, 0);
    chk("R1", "truncErr", truncErr, 0);
    chk("R1", "payLen", payLen, 0);
    chk("R1", "inReady", inReady, 1);

    // R2 skip bytes hold tag letters; R4 empty field; R8 trailing bytes dropped
    buildFile(8'h5E, 3, 0, 2, 1, 6, 6, -1, 1, 2);
    runStream(0, 0, 2000);
    chk("R2", "header completed over tag-like skip bytes", hdrSeen, 1);
    chk("R4", "header completed with empty field", hdrSeen, 1);
    chk("R10", "no truncation on trailing end mark", truncErr, 0);
    checkPayload("R8");

    // R3 16-bit field length, R11 backpressure and input gaps, exact end
    doRestart();
    buildFile(0, 258, 1, 0, 5, 10, 10, -1, 1, 0);
    runStream(5, 4, 5000);
    chk("R3", "header completed after 258-byte field", hdrSeen, 1);
    chk("R5", "payLen value", payLen, 10);
    chk("R11", "upstream stalled at least once", stallSeen > 0, 1);
    chk("R10", "end mark on final payload byte", truncErr, 0);
    checkPayload("R8");

    // R9 zero payload length
    doRestart();
    buildFile(7, 1, 1, 1, 1, 0, 0, -1, 1, 3);
    runStream(0, 0, 2000);
    chk("R9", "hdrDone with empty payload", hdrSeen, 1);
    chk("R9", "no payload byte", rxQ.size(), 0);
    chk("R9", "payLen zero", payLen, 0);

    // R6 wrong tag at the third position
    doRestart();
    buildFile(1, 2, 2, 2, 2, 4, 4, 2, 1, 0);
    runStream(0, 0, 2000);
    chk("R6", "fmtErr set", fmtErr, 1);
    chk("R6", "no header done", hdrSeen, 0);
    chk("R6", "no payload byte", rxQ.size(), 0);

    // R6 wrong final tag
    doRestart();
    buildFile(1, 0, 0, 0, 0, 4, 4, 4, 0, 0);
    runStream(0, 0, 2000);
    chk("R6", "fmtErr on last tag", fmtErr, 1);

    // R10 truncated payload
    doRestart();
    buildFile(3, 1, 2, 3, 4, 8, 5, -1, 1, 0);
    runStream(3, 5, 2000);
    chk("R10", "truncErr set", truncErr, 1);
    checkPayload("R10");

    // R10 truncation inside the header
    doRestart();
    buildFile(3, 4, 4, 4, 4, 2, 2, -1, 0, 0);
    endQ[20] = 1;
    runStream(0, 0, 2000);
    chk("R10", "truncErr in header", truncErr, 1);
    chk("R10", "no header done", hdrSeen, 0);

    // R12 restart mid-payload, then a clean image
    doRestart();
    buildFile(9, 0, 0, 0, 0, 20, 20, -1, 1, 0);
    repeat (2) void'(stimQ.pop_back());
    void'(endQ.pop_back()); void'(endQ.pop_back());
    endQ[endQ.size() - 1] = 0;
    runStream(0, 0, 2000);
    doRestart();
    buildFile(9, 0, 1, 0, 1, 3, 3, -1, 1, 0);
    runStream(0, 0, 2000);
    chk("R12", "header after restart", hdrSeen, 1);
    checkPayload("R12");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule